// File: doc/BRIEF.md
# Serial Output Sequencer for a 16-bit Sampling Converter

This block models the digital output side of a 16-bit successive-approximation converter that talks over a three-wire serial port. It is clocked by the port's data clock, armed by an active-low chip select, and fed a parallel signed result by a stub that replaces the analog conversion. Each transaction has a fixed order of phases. Four clock periods are kept quiet as the sample phase. One period carries a low null bit. The word then goes out most significant bit first. Bit 0 is shared as the turning point, after which the word repeats least significant bit first. Last, the line floats.

The data line is presented as a value/enable pair (`sdo_d`, `sdo_en`) that a pad cell combines into a tri-state driver. Releasing chip select at any moment clears the sequencer without waiting for a clock. This lets a host short-cycle a transfer after as many bits as it needs. Two flags report power state. One flags full shutdown while the port is deselected. The other flags that the analog section is idle once every bit has been decided.

Top module: `sar_serial_seq`

## Requirements
- R1: While `rst_n` is low or `cs_n` is high, `sdo_en` is 0 and both `pd_full` and `pd_analog` are 1; `pd_full` is 0 whenever `rst_n` is high and `cs_n` is low.
- R2: After `cs_n` falls, `sdo_en` stays 0 through the first four falling edges of `dclk` (the sample phase), and `pd_analog` is 0.
- R3: The fifth falling edge after `cs_n` falls enables the line (`sdo_en`=1) and drives a null bit `sdo_d`=0 for one clock period.
- R4: Falling edges 6 through 21 drive the word most significant bit first: falling edge k drives bit 21-k.
- R5: Falling edges 22 through 36 drive the word again least significant bit first, starting at bit 1: falling edge k drives bit k-21.
- R6: From falling edge 37 on, `sdo_en` is 0 and stays 0 for any number of further clocks until `cs_n` goes high and low again.
- R7: The word is taken from `conv_result` at the fifth falling edge; changes on `conv_result` later in the same transaction do not change the bits sent.
- R8: `pd_analog` rises at falling edge 22, once all bits have been decided, and stays 1 while `cs_n` is low.
- R9: Raising `cs_n` at any time clears `sdo_en` at once without a clock edge, and the next low period of `cs_n` restarts the sequence from the sample phase with no state left from the aborted transfer.
- R10: Words are two's complement and pass through unaltered: 0x7FFF (positive full scale minus one step), 0x0000 (zero), 0xFFFF (minus one step) and 0x8000 (negative full scale) are each sent bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Serial data clock; the outputs change on its falling edge |
| cs_n | input | 1 | Active-low chip select; high clears the sequencer asynchronously |
| conv_result | input | 16 | Signed result from the conversion stub |
| sdo_d | output | 1 | Serial data value |
| sdo_en | output | 1 | Serial data drive enable; 0 means the line floats |
| pd_full | output | 1 | Whole block powered down |
| pd_analog | output | 1 | Analog section powered down |

## Verification
Every serial result is due on the falling edge it is numbered by, counted from the fall of chip select. That edge passes through one register stage, so the value is stable from that edge until the next. The bench therefore samples seven tenths of a period after each falling edge, while the clock is high and before the next edge. An abort acts with no register in the path, so its effect on the enable and power flags is checked one time unit after chip select rises. The expected bit for falling edge k is computed arithmetically from k and the word sent. Sweeps of walking-one, walking-zero and full-scale codes then cover every bit position in both orders.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_ARMED  = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_NULL   = 3'd2,
        ST_MSB    = 3'd3,
        ST_LSB    = 3'd4,
        ST_FLOAT  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/sar_seq_counter.sv
module sar_seq_counter #(
    parameter int CNT_W   = 6,
    parameter int SAT_VAL = 37
) (
    input  logic             dclk,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VAL);

    always_ff @(negedge dclk or posedge clear) begin
        if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int NULL_AT  = 5,
    parameter int MSB_LAST = 21,
    parameter int LSB_LAST = 36
) (
    input  logic             dclk,
    input  logic             clear,
    input  logic [CNT_W-1:0] cnt_q,
    output seq_state_e       state_q,
    output logic             load_word,
    output logic             line_en,
    output logic             analog_idle
);

    localparam logic [CNT_W-1:0] LAST_SAMPLE = CNT_W'(NULL_AT - 1);
    localparam logic [CNT_W-1:0] END_MSB     = CNT_W'(MSB_LAST);
    localparam logic [CNT_W-1:0] END_LSB     = CNT_W'(LSB_LAST);

    seq_state_e state_d;

    // next-state logic: each falling edge advances the count by one
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:  state_d = (LAST_SAMPLE == '0) ? ST_NULL : ST_SAMPLE;
            ST_SAMPLE: if (cnt_q == LAST_SAMPLE) state_d = ST_NULL;
            ST_NULL:   state_d = ST_MSB;
            ST_MSB:    if (cnt_q == END_MSB) state_d = ST_LSB;
            ST_LSB:    if (cnt_q == END_LSB) state_d = ST_FLOAT;
            ST_FLOAT:  state_d = ST_FLOAT;
            default:   state_d = ST_ARMED;
        endcase
    end

    // state register, cleared asynchronously by deselect or reset
    always_ff @(negedge dclk or posedge clear) begin
        if (clear) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        line_en     = 1'b0;
        analog_idle = 1'b0;
        unique case (state_q)
            ST_ARMED, ST_SAMPLE: begin
                line_en     = 1'b0;
                analog_idle = 1'b0;
            end
            ST_NULL, ST_MSB: begin
                line_en     = 1'b1;
                analog_idle = 1'b0;
            end
            ST_LSB: begin
                line_en     = 1'b1;
                analog_idle = 1'b1;
            end
            ST_FLOAT: begin
                line_en     = 1'b0;
                analog_idle = 1'b1;
            end
            default: begin
                line_en     = 1'b0;
                analog_idle = 1'b0;
            end
        endcase
    end

    assign load_word = (state_d == ST_NULL) && (state_q != ST_NULL);

endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
    import sar_seq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 6,
    parameter int MSB_LAST = 21
) (
    input  logic              dclk,
    input  logic              clear,
    input  logic              load_word,
    input  logic [DATA_W-1:0] conv_result,
    input  seq_state_e        state_q,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic              bit_out
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] PIVOT = CNT_W'(MSB_LAST);

    logic [DATA_W-1:0] word_q;
    logic [CNT_W-1:0]  idx_wide;
    logic [IDX_W-1:0]  idx;

    // word held for the whole transaction
    always_ff @(negedge dclk or posedge clear) begin
        if (clear) begin
            word_q <= '0;
        end else if (load_word) begin
            word_q <= conv_result;
        end
    end

    // bit index: counts down before the pivot, up after it
    always_comb begin
        idx_wide = '0;
        unique case (state_q)
            ST_MSB:  idx_wide = PIVOT - cnt_q;
            ST_LSB:  idx_wide = cnt_q - PIVOT;
            default: idx_wide = '0;
        endcase
    end

    assign idx = idx_wide[IDX_W-1:0];

    always_comb begin
        unique case (state_q)
            ST_MSB, ST_LSB: bit_out = word_q[idx];
            default:        bit_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sar_seq_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int SAMPLE_FALLS = 5
) (
    input  logic              rst_n,
    input  logic              dclk,
    input  logic              cs_n,
    input  logic [DATA_W-1:0] conv_result,
    output logic              sdo_d,
    output logic              sdo_en,
    output logic              pd_full,
    output logic              pd_analog
);

    localparam int NULL_AT   = SAMPLE_FALLS;
    localparam int MSB_FIRST = NULL_AT + 1;
    localparam int MSB_LAST  = MSB_FIRST + DATA_W - 1;
    localparam int LSB_LAST  = MSB_LAST + DATA_W - 1;
    localparam int FLOAT_AT  = LSB_LAST + 1;
    localparam int CNT_W     = $clog2(FLOAT_AT + 1);

    logic             clear;
    logic [CNT_W-1:0] cnt_q;
    seq_state_e       state_q;
    logic             load_word;
    logic             line_en;
    logic             analog_idle;
    logic             bit_out;

    assign clear = !rst_n || cs_n;

    sar_seq_counter #(
        .CNT_W   (CNT_W),
        .SAT_VAL (FLOAT_AT)
    ) u_cnt (
        .dclk  (dclk),
        .clear (clear),
        .cnt_q (cnt_q)
    );

    sar_seq_fsm #(
        .CNT_W    (CNT_W),
        .NULL_AT  (NULL_AT),
        .MSB_LAST (MSB_LAST),
        .LSB_LAST (LSB_LAST)
    ) u_fsm (
        .dclk        (dclk),
        .clear       (clear),
        .cnt_q       (cnt_q),
        .state_q     (state_q),
        .load_word   (load_word),
        .line_en     (line_en),
        .analog_idle (analog_idle)
    );

    sar_seq_datapath #(
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .MSB_LAST (MSB_LAST)
    ) u_dp (
        .dclk        (dclk),
        .clear       (clear),
        .load_word   (load_word),
        .conv_result (conv_result),
        .state_q     (state_q),
        .cnt_q       (cnt_q),
        .bit_out     (bit_out)
    );

    assign sdo_en    = line_en;
    assign sdo_d     = line_en & bit_out;
    assign pd_full   = clear;
    assign pd_analog = clear | analog_idle;

endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker
    import sar_seq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic             dclk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sdo_d,
    input logic             sdo_en,
    input logic             pd_analog,
    input seq_state_e       state_q,
    input logic [CNT_W-1:0] cnt_q
);

    a_r3_null_low: assert property (@(posedge dclk) disable iff (!rst_n || cs_n)
        $rose(sdo_en) |-> (sdo_d == 1'b0));

    a_r2_sample_quiet: assert property (@(posedge dclk) disable iff (!rst_n || cs_n)
        (state_q == ST_SAMPLE) |-> (!sdo_en && !pd_analog));

    a_r6_float_sticks: assert property (@(negedge dclk) disable iff (!rst_n || cs_n)
        (state_q == ST_FLOAT) |=> (state_q == ST_FLOAT && !sdo_en));

    a_r4_count_steps: assert property (@(negedge dclk) disable iff (!rst_n || cs_n)
        (state_q == ST_MSB) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r8_idle_not_driving_msb: assert property (@(posedge dclk) disable iff (!rst_n || cs_n)
        (state_q == ST_MSB) |-> !pd_analog);

    a_r9_deselect_quiet: assert property (@(posedge dclk) disable iff (!rst_n)
        cs_n |-> (!sdo_en && pd_analog));

endmodule

bind sar_serial_seq sar_seq_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .dclk      (dclk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdo_d     (sdo_d),
    .sdo_en    (sdo_en),
    .pd_analog (pd_analog),
    .state_q   (state_q),
    .cnt_q     (cnt_q)
);

// File: tb/sar_serial_seq_bench.sv
module sar_serial_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;

    logic          rst_n = 1'b0;
    logic          dclk  = 1'b1;
    logic          cs_n  = 1'b1;
    logic [DW-1:0] conv_result = '0;
    logic          sdo_d, sdo_en, pd_full, pd_analog;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) dclk = ~dclk;

    sar_serial_seq u_sar_serial_seq (
        .rst_n       (rst_n),
        .dclk        (dclk),
        .cs_n        (cs_n),
        .conv_result (conv_result),
        .sdo_d       (sdo_d),
        .sdo_en      (sdo_en),
        .pd_full     (pd_full),
        .pd_analog   (pd_analog)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // expected outputs for falling edge k of a transaction sending word w
    task automatic check_edge(input int k, input logic [DW-1:0] w);
        if (k < 5) begin
            check("R2 en", int'(sdo_en), 0);
            check("R2 pd_analog", int'(pd_analog), 0);
        end else if (k == 5) begin
            check("R3 en", int'(sdo_en), 1);
            check("R3 null", int'(sdo_d), 0);
        end else if (k <= 21) begin
            check("R4 en", int'(sdo_en), 1);
            check("R4 bit", int'(sdo_d), int'(w[21-k]));
            check("R8 pd_analog", int'(pd_analog), 0);
        end else if (k <= 36) begin
            check("R5 en", int'(sdo_en), 1);
            check("R5 bit", int'(sdo_d), int'(w[k-21]));
            check("R8 pd_analog", int'(pd_analog), 1);
        end else begin
            check("R6 en", int'(sdo_en), 0);
            check("R8 pd_analog", int'(pd_analog), 1);
        end
        check("R1 pd_full", int'(pd_full), 0);
    endtask

    // one transaction: nf falling edges, optional mid-transfer input change
    task automatic transact(input logic [DW-1:0] w, input int nf, input bit scramble);
        @(negedge dclk);
        #2;
        conv_result = w;
        cs_n = 1'b0;
        #1;
        check("R2 en at select", int'(sdo_en), 0);
        check("R1 pd_full low", int'(pd_full), 0);
        for (int k = 1; k <= nf; k++) begin
            @(negedge dclk);
            #7;
            check_edge(k, w);
            if (scramble && k == 8) conv_result = ~w;  // R7: late change ignored
        end
        @(posedge dclk);
        #1;
        cs_n = 1'b1;
        #1;
        check("R9 en after abort", int'(sdo_en), 0);
        check("R1 pd_full", int'(pd_full), 1);
        check("R1 pd_analog", int'(pd_analog), 1);
        for (int j = 0; j < 2; j++) begin
            @(negedge dclk);
            #7;
            check("R1 en deselected", int'(sdo_en), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        check("R1 en in reset", int'(sdo_en), 0);
        check("R1 pd_full in reset", int'(pd_full), 1);
        check("R1 pd_analog in reset", int'(pd_analog), 1);
        cs_n = 1'b0;
        #1;
        check("R1 pd_full in reset", int'(pd_full), 1);
        cs_n = 1'b1;
        rst_n = 1'b1;
        #(CLK_PERIOD * 2);

        // R10: full-scale and zero codes, run past the float point (R6)
        transact(16'h7FFF, 45, 0);
        transact(16'h0000, 45, 0);
        transact(16'hFFFF, 45, 0);
        transact(16'h8000, 45, 0);
        // R4/R5 walking one and walking zero over all positions
        for (int b = 0; b < DW; b++) transact(DW'(1) << b, 38, 0);
        for (int b = 0; b < DW; b++) transact(~(DW'(1) << b), 38, 0);
        // R7: input changes after capture
        transact(16'hA5C3, 40, 1);
        transact(16'h3C5A, 40, 1);
        // R9: short cycles at various points, each followed by a fresh cycle
        transact(16'hFFFF, 3, 0);
        transact(16'h1234, 40, 0);
        transact(16'hFFFF, 5, 0);
        transact(16'h0F0F, 40, 0);
        transact(16'hFFFF, 12, 0);
        transact(16'h8001, 40, 0);
        transact(16'hFFFF, 21, 0);
        transact(16'h7FFE, 40, 0);
        transact(16'hFFFF, 30, 0);
        transact(16'h4001, 40, 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule